// File: doc/BRIEF.md
# Signed Add / Subtract / Negate Unit

This block is a purely combinational arithmetic stage for signed two's complement integers of configurable width. It accepts two operands and a two-bit operation code, and it produces the wrapped N-bit result, an overflow flag, and a copy of the result widened to twice the width. The widened copy carries the sign into the upper half.

All three operations share one ripple-carry adder. Add feeds the operands straight in. Subtract routes the second operand through a bit-inverting path and sets the carry-in to one, so the adder forms the first operand plus the negated second operand. Negate inverts the first operand, pairs it with zero and sets the carry-in to one. The carry out of the top bit is discarded.

Overflow is judged on the operands the adder actually receives. For negation it is judged on whether the sign bit flipped. The unit is meant to sit inside a datapath stage that registers its outputs.

Top module: `tc_addsub_unit`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals (opd_a + opd_b) modulo 2^N, and any carry beyond the top bit is dropped.
- R2: With op_sel = 2'b01 (subtract), result equals (opd_a - opd_b) modulo 2^N.
- R3: With op_sel = 2'b10 (negate), result equals (-opd_a) modulo 2^N. Negating zero gives zero with ovf = 0.
- R4: For add, ovf is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it, which is the case where the true sum lies outside [-2^(N-1), 2^(N-1)-1].
- R5: For subtract, ovf is 1 exactly when the true difference lies outside [-2^(N-1), 2^(N-1)-1]. This includes every opd_a >= 0 paired with opd_b equal to the most negative value.
- R6: For negate, ovf is 1 only when opd_a is the most negative value (bit N-1 set, all other bits clear). In that case result keeps the same pattern.
- R7: With op_sel = 2'b11, result and result_wide are zero and ovf is 0, whatever the operands.
- R8: result_wide[N-1:0] equals result, and every bit of result_wide[2N-1:N] equals result[N-1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | N | First operand, two's complement |
| opd_b | input | N | Second operand, two's complement |
| op_sel | input | 2 | 00 add, 01 subtract, 10 negate opd_a, 11 zero output |
| result | output | N | Wrapped N-bit result |
| ovf | output | 1 | Signed overflow flag |
| result_wide | output | 2N | Sign-extended copy of result |

## Verification
The bench builds the unit with N = 8. At that width all 65,536 operand pairs under each of the four operation codes can be swept. This puts every boundary within reach: the most negative value as minuend, as subtrahend and as negation input, zero negation, and every sign combination at the edge of the range. Expected results come from plain integer arithmetic on sign-extended operands, and the bench checks the range directly.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_NEG  = 2'b10,
    OP_ZERO = 2'b11
  } tcu_op_e;

endpackage

// File: rtl/tcu_operand_mux.sv
// Chooses the two adder inputs and the carry-in for each operation.
module tcu_operand_mux
  import tcu_pkg::*;
#(
  parameter int N = 8
) (
  input  tcu_op_e        op,
  input  logic [N-1:0]   opd_a,
  input  logic [N-1:0]   opd_b,
  output logic [N-1:0]   add_x,
  output logic [N-1:0]   add_y,
  output logic           add_cin
);

  logic [N-1:0] a_inv;
  logic [N-1:0] b_inv;

  // Complement path: one inverter per bit
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_inv
      assign a_inv[gi] = ~opd_a[gi];
      assign b_inv[gi] = ~opd_b[gi];
    end
  endgenerate

  always_comb begin
    add_x   = '0;
    add_y   = '0;
    add_cin = 1'b0;
    unique case (op)
      OP_ADD: begin
        add_x   = opd_a;
        add_y   = opd_b;
        add_cin = 1'b0;
      end
      OP_SUB: begin
        add_x   = opd_a;
        add_y   = b_inv;
        add_cin = 1'b1;
      end
      OP_NEG: begin
        add_x   = a_inv;
        add_y   = '0;
        add_cin = 1'b1;
      end
      OP_ZERO: begin
        add_x   = '0;
        add_y   = '0;
        add_cin = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/tcu_ripple_adder.sv
// N-bit ripple-carry adder. The carry out of the top bit is never formed.
module tcu_ripple_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         cin,
  output logic [N-1:0] sum
);

  logic [N-1:0] carry;

  assign carry[0] = cin;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      assign sum[gi] = x[gi] ^ y[gi] ^ carry[gi];
      if (gi < N - 1) begin : g_carry
        assign carry[gi+1] = (x[gi] & y[gi]) | (carry[gi] & (x[gi] ^ y[gi]));
      end
    end
  endgenerate

endmodule

// File: rtl/tcu_flag_unit.sv
// Signed overflow detection for each operation.
module tcu_flag_unit
  import tcu_pkg::*;
#(
  parameter int N = 8
) (
  input  tcu_op_e      op,
  input  logic [N-1:0] opd_a,
  input  logic         x_msb,
  input  logic         y_msb,
  input  logic         sum_msb,
  output logic         ovf
);

  logic a_nonzero;
  logic same_sign_in;
  logic sign_moved;

  assign a_nonzero    = |opd_a;
  assign same_sign_in = ~(x_msb ^ y_msb);
  assign sign_moved   = sum_msb ^ x_msb;

  always_comb begin
    ovf = 1'b0;
    unique case (op)
      // Operands of like sign and a result of the other sign
      OP_ADD, OP_SUB: ovf = same_sign_in & sign_moved;
      // A nonzero input whose sign bit fails to flip
      OP_NEG:         ovf = a_nonzero & ~(sum_msb ^ opd_a[N-1]);
      OP_ZERO:        ovf = 1'b0;
    endcase
  end

endmodule

// File: rtl/tcu_sign_ext.sv
module tcu_sign_ext #(
  parameter int N = 8,
  parameter int W = 2 * N
) (
  input  logic [N-1:0] narrow,
  output logic [W-1:0] wide
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      if (gi < N) begin : g_copy
        assign wide[gi] = narrow[gi];
      end else begin : g_sign
        assign wide[gi] = narrow[N-1];
      end
    end
  endgenerate

endmodule

// File: rtl/tc_addsub_unit.sv
module tc_addsub_unit
  import tcu_pkg::*;
#(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input  logic [N-1:0] opd_a,
  input  logic [N-1:0] opd_b,
  input  logic [1:0]   op_sel,
  output logic [N-1:0] result,
  output logic         ovf,
  output logic [W-1:0] result_wide
);

  tcu_op_e      op;
  logic [N-1:0] add_x;
  logic [N-1:0] add_y;
  logic         add_cin;
  logic [N-1:0] sum;
  logic         ovf_raw;
  logic         zero_op;

  assign op      = tcu_op_e'(op_sel);
  assign zero_op = (op == OP_ZERO);

  tcu_operand_mux #(.N(N)) u_mux (
    .op      (op),
    .opd_a   (opd_a),
    .opd_b   (opd_b),
    .add_x   (add_x),
    .add_y   (add_y),
    .add_cin (add_cin)
  );

  tcu_ripple_adder #(.N(N)) u_add (
    .x   (add_x),
    .y   (add_y),
    .cin (add_cin),
    .sum (sum)
  );

  tcu_flag_unit #(.N(N)) u_flag (
    .op      (op),
    .opd_a   (opd_a),
    .x_msb   (add_x[N-1]),
    .y_msb   (add_y[N-1]),
    .sum_msb (sum[N-1]),
    .ovf     (ovf_raw)
  );

  assign result = zero_op ? '0 : sum;
  assign ovf    = zero_op ? 1'b0 : ovf_raw;

  tcu_sign_ext #(.N(N), .W(W)) u_ext (
    .narrow (result),
    .wide   (result_wide)
  );

endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input logic [N-1:0] opd_a,
  input logic [N-1:0] opd_b,
  input logic [1:0]   op_sel,
  input logic [N-1:0] result,
  input logic         ovf,
  input logic [W-1:0] result_wide
);

  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

  always_comb begin
    if (op_sel == 2'b00) begin
      p_add_wrap_r1: assert (result == N'(opd_a + opd_b));
      p_add_ovf_r4:  assert (ovf == ((opd_a[N-1] == opd_b[N-1]) && (result[N-1] != opd_a[N-1])));
    end
    if (op_sel == 2'b01) begin
      p_sub_wrap_r2: assert (result == N'(opd_a - opd_b));
      p_sub_ovf_r5:  assert (ovf == ((opd_a[N-1] != opd_b[N-1]) && (result[N-1] != opd_a[N-1])));
    end
    if (op_sel == 2'b10) begin
      p_neg_wrap_r3: assert (N'(result + opd_a) == '0);
      p_neg_ovf_r6:  assert (ovf == (opd_a == MOST_NEG));
    end
    if (op_sel == 2'b11) begin
      p_zero_out_r7: assert (result == '0 && !ovf);
    end
    p_wide_ext_r8: assert (result_wide == {{N{result[N-1]}}, result});
  end

endmodule

bind tc_addsub_unit tcu_checker #(.N(N)) u_tcu_checker (
  .opd_a       (opd_a),
  .opd_b       (opd_b),
  .op_sel      (op_sel),
  .result      (result),
  .ovf         (ovf),
  .result_wide (result_wide)
);

// File: tb/tc_addsub_unit_bench.sv
`timescale 1ns/1ps
module tc_addsub_unit_bench;

  localparam int N         = 8;
  localparam int W         = 2 * N;
  localparam int CLK_PER   = 10;
  localparam int WATCH_CYC = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] opd_a = '0;
  logic [N-1:0] opd_b = '0;
  logic [1:0]   op_sel = 2'b11;
  logic [N-1:0] result;
  logic         ovf;
  logic [W-1:0] result_wide;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  tc_addsub_unit #(.N(N)) u_tc_addsub_unit (
    .opd_a       (opd_a),
    .opd_b       (opd_b),
    .op_sel      (op_sel),
    .result      (result),
    .ovf         (ovf),
    .result_wide (result_wide)
  );

  task automatic cmp(input string tag, input longint act, input longint exp,
                     input int a, input int b, input int op);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      if (n_bad <= 20)
        $display("FAIL %s op=%0d a=%0d b=%0d actual=%0h expected=%0h",
                 tag, op, a, b, act, exp);
    end
  endtask

  task automatic apply(input int op, input int ai, input int bi);
    int sa, sb, full, exp_r, exp_w;
    bit exp_o;
    opd_a  = N'(ai);
    opd_b  = N'(bi);
    op_sel = 2'(op);
    #1;
    sa = (ai >= 128) ? ai - 256 : ai;
    sb = (bi >= 128) ? bi - 256 : bi;
    case (op)
      0: full = sa + sb;
      1: full = sa - sb;
      2: full = -sa;
      default: full = 0;
    endcase
    exp_o = (full > 127) || (full < -128);
    exp_r = full & 8'hFF;
    exp_w = full & 16'hFFFF;
    if (exp_o) exp_w = ((exp_r >= 128) ? 32'hFF00 : 0) | exp_r;
    case (op)
      0: begin
        cmp("R1", longint'(result), longint'(exp_r), sa, sb, op);
        cmp("R4", longint'(ovf), longint'(exp_o), sa, sb, op);
      end
      1: begin
        cmp("R2", longint'(result), longint'(exp_r), sa, sb, op);
        cmp("R5", longint'(ovf), longint'(exp_o), sa, sb, op);
      end
      2: begin
        cmp("R3", longint'(result), longint'(exp_r), sa, sb, op);
        cmp("R6", longint'(ovf), longint'(exp_o), sa, sb, op);
      end
      default: begin
        cmp("R7", longint'(result), 0, sa, sb, op);
        cmp("R7", longint'(ovf), 0, sa, sb, op);
      end
    endcase
    cmp("R8", longint'(result_wide), longint'(exp_w), sa, sb, op);
  endtask

  initial begin
    #(3*CLK_PER);
    rst_n = 1'b1;
    #1;
    // reset/idle state: zero op with zero operands
    cmp("R7", longint'(result), 0, 0, 0, 3);
    cmp("R7", longint'(ovf), 0, 0, 0, 3);
    // named corners
    apply(2, 0, 0);        // R3: negate zero -> 0, no overflow
    apply(2, 128, 0);      // R6: negate most negative
    apply(1, 0, 128);      // R5: 0 - (-128)
    apply(0, 127, 1);      // R4: positive overflow
    apply(0, 128, 255);    // R4: negative overflow
    apply(0, 255, 1);      // R1: carry out dropped
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          apply(op, a, b);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCH_CYC; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule